// File: doc/BRIEF.md
# Asynchronous Static Memory Access Controller

This block sits between a synchronous host and an external asynchronous static memory of 131,072 bytes. The host hands it one read or one write at a time over a valid/ready port. The controller turns that request into a sequence of memory strobes. Every strobe edge is placed on a system clock edge, and each phase lasts a whole number of cycles. Those cycle counts are derived at elaboration from nanosecond minimums and the clock period, all of which are parameters.

The memory has two chip selects of opposite polarity, an active-low write enable and an active-low output enable. A write takes effect only while both selects and the write enable are all active, so the controller selects the chip first and opens the write window one cycle later with the write enable. It closes the window with the write enable as well, and keeps address and data unchanged for a hold phase afterwards. A read asserts the selects and the output enable together and captures the bus once the access time has run. The controller then waits out the memory's bus-release time before it can drive the bus again. Read data returns on a separate one-cycle strobe.

The data bus is presented as separate drive, sample and drive-enable signals, so the tri-state pad can sit outside the block.

Top module: `asram_ctl`

## Requirements
- R1: After reset and whenever idle, the memory is in standby: active-low select high, active-high select low, write enable high, output enable high, data driver off. The request ready is high and the read-data strobe is low.
- R2: Ready is high only in the idle state. A request is taken on a clock edge where valid and ready are both high. Request inputs presented while ready is low have no effect on the memory or on the stored data.
- R3: The cycle after a write is taken, the controller presents the address and drives the data. It asserts both selects with output enable high and write enable still high, and holds this setup for N_AS = max(1, ceil(tAS/T)) cycles.
- R4: Write enable then goes low for N_WP cycles. N_WP is the largest of ceil(tWP/T), ceil(tCW/T)-N_AS, ceil(tAW/T)-N_AS and ceil(tDW/T). Address and write data stay constant throughout this window.
- R5: After write enable rises, selects, address and driven data are held for N_WT cycles, where N_WT = max(ceil(max(tDH,tWR)/T) at least 1, ceil(tWC/T)-N_AS-N_WP). The controller then returns to idle and releases the driver. The written byte is stored at the presented address.
- R6: The cycle after a read is taken, both selects and output enable are asserted together. Write enable stays high and the driver stays off for N_RD = max(ceil(tRC/T), ceil(tAA/T), ceil(tOE/T)) cycles.
- R7: The data bus is captured on the edge that ends the last read-access cycle. The read-data strobe is high for exactly the following cycle, carrying the byte last written to that address (zero if never written).
- R8: After a read, the controller stays in standby for N_TA = ceil(tHZ/T) cycles before ready returns. The data driver never turns on within N_TA cycles of output enable rising.
- R9: Write enable is never low unless both selects are active and output enable is high. The data driver is never on while output enable is low.
- R10: All cycle counts use ceiling division of nanoseconds by the clock period, with a floor of one cycle. With T = 8 ns and the fast-grade defaults: N_AS=1, N_WP=5, N_WT=1, N_RD=7, N_TA=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data to drive onto the bus |
| mem_dq_in | input | DATA_W | Data sampled from the bus |
| mem_dq_oe | output | 1 | Bus driver enable |

## Verification
Two events can coincide here. The first is the memory still driving the bus during its release time after a read. The second is the controller turning its own driver on for a write that was queued behind that read. The bench provokes this by holding a write request valid while a read is finishing, so the write is taken on the first idle edge. A memory model keeps driving for the release time after output enable rises and flags any cycle in which both sides drive. A cycle-accurate reference compares every strobe on every clock.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WSETUP = 3'd1,
      ST_WPULSE = 3'd2,
      ST_WHOLD  = 3'd3,
      ST_RACC   = 3'd4,
      ST_RTURN  = 3'd5
   } acc_state_e;

   // nanoseconds to whole clock cycles, never below one
   function automatic int ns2cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_ctl_timer.sv
module asram_ctl_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_ctl_seq.sv
module asram_ctl_seq
   import asram_ctl_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int N_AS  = 1,
   parameter int N_WP  = 4,
   parameter int N_WT  = 1,
   parameter int N_RD  = 6,
   parameter int N_TA  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             cap_rd,
   output logic             release_bus,
   output logic             ready_q,
   output logic             sel_q,
   output logic             wen_q,
   output logic             oen_q,
   output logic             drv_q
);

   acc_state_e st_q, st_d;

   assign accept = ready_q && req_valid;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  st_d    = ST_WSETUP;
                  tmr_val = CNT_W'(N_AS - 1);
               end else begin
                  st_d    = ST_RACC;
                  tmr_val = CNT_W'(N_RD - 1);
               end
            end
         end
         ST_WSETUP: begin
            if (tmr_done) begin
               st_d     = ST_WPULSE;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(N_WP - 1);
            end
         end
         ST_WPULSE: begin
            if (tmr_done) begin
               st_d     = ST_WHOLD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(N_WT - 1);
            end
         end
         ST_WHOLD: begin
            if (tmr_done) st_d = ST_IDLE;
         end
         ST_RACC: begin
            if (tmr_done) begin
               st_d     = ST_RTURN;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(N_TA - 1);
            end
         end
         ST_RTURN: begin
            if (tmr_done) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign cap_rd      = (st_q == ST_RACC) && tmr_done;
   assign release_bus = ((st_q == ST_WHOLD) || (st_q == ST_RTURN)) && tmr_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_IDLE;
      else
         st_q <= st_d;
   end

   // strobes come straight from flops so no decode hazard reaches the pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b1;
         sel_q   <= 1'b0;
         wen_q   <= 1'b0;
         oen_q   <= 1'b0;
         drv_q   <= 1'b0;
      end else begin
         ready_q <= (st_d == ST_IDLE);
         sel_q   <= (st_d == ST_WSETUP) || (st_d == ST_WPULSE) ||
                    (st_d == ST_WHOLD)  || (st_d == ST_RACC);
         wen_q   <= (st_d == ST_WPULSE);
         oen_q   <= (st_d == ST_RACC);
         drv_q   <= (st_d == ST_WSETUP) || (st_d == ST_WPULSE) ||
                    (st_d == ST_WHOLD);
      end
   end

endmodule

// File: rtl/asram_ctl_dpath.sv
module asram_ctl_dpath #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter bit PARK_ADDR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              is_write,
   input  logic              release_bus,
   input  logic              cap_rd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);

   generate
      if (PARK_ADDR) begin : g_park
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               addr_q <= '0;
            else if (accept)
               addr_q <= req_addr;
            else if (release_bus)
               addr_q <= '0;
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               addr_q <= '0;
            else if (accept)
               addr_q <= req_addr;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wdata_q <= '0;
      else if (accept && is_write)
         wdata_q <= req_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= cap_rd;
         if (cap_rd) rdata_q <= dq_in;
      end
   end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_ctl_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int T_WC_NS   = 55,
   parameter int T_WP_NS   = 40,
   parameter int T_CW_NS   = 45,
   parameter int T_AW_NS   = 45,
   parameter int T_DW_NS   = 25,
   parameter int T_AS_NS   = 0,
   parameter int T_WR_NS   = 0,
   parameter int T_DH_NS   = 0,
   parameter int T_RC_NS   = 55,
   parameter int T_AA_NS   = 55,
   parameter int T_OE_NS   = 25,
   parameter int T_HZ_NS   = 20,
   parameter bit PARK_ADDR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int N_AS  = ns2cyc(T_AS_NS, CLK_NS);
   localparam int N_WP  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)),
                               imax(ns2cyc(T_CW_NS, CLK_NS) - N_AS,
                                    ns2cyc(T_AW_NS, CLK_NS) - N_AS));
   localparam int N_WT  = imax(ns2cyc(imax(T_DH_NS, T_WR_NS), CLK_NS),
                               ns2cyc(T_WC_NS, CLK_NS) - N_AS - N_WP);
   localparam int N_RD  = imax(ns2cyc(T_RC_NS, CLK_NS),
                               imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)));
   localparam int N_TA  = ns2cyc(T_HZ_NS, CLK_NS);
   localparam int N_MAX = imax(imax(N_AS, N_WP), imax(imax(N_WT, N_RD), N_TA));
   localparam int CNT_W = $clog2(N_MAX + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctl: address and data widths must be positive");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("asram_ctl: clock period must be at least 1 ns");
      end
      if (T_WC_NS < 0 || T_WP_NS < 0 || T_CW_NS < 0 || T_AW_NS < 0 || T_DW_NS < 0 ||
          T_AS_NS < 0 || T_WR_NS < 0 || T_DH_NS < 0 || T_RC_NS < 0 || T_AA_NS < 0 ||
          T_OE_NS < 0 || T_HZ_NS < 0) begin : g_bad_timing
         $error("asram_ctl: timing minimums cannot be negative");
      end
   endgenerate

   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic             accept, cap_rd, release_bus;
   logic             sel_q, wen_q, oen_q, drv_q;

   asram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   asram_ctl_seq #(
      .CNT_W (CNT_W),
      .N_AS  (N_AS),
      .N_WP  (N_WP),
      .N_WT  (N_WT),
      .N_RD  (N_RD),
      .N_TA  (N_TA)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .tmr_done    (tmr_done),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .accept      (accept),
      .cap_rd      (cap_rd),
      .release_bus (release_bus),
      .ready_q     (req_ready),
      .sel_q       (sel_q),
      .wen_q       (wen_q),
      .oen_q       (oen_q),
      .drv_q       (drv_q)
   );

   asram_ctl_dpath #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PARK_ADDR (PARK_ADDR)
   ) u_dpath (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .is_write    (req_write),
      .release_bus (release_bus),
      .cap_rd      (cap_rd),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .dq_in       (mem_dq_in),
      .addr_q      (mem_addr),
      .wdata_q     (mem_dq_out),
      .rdata_q     (rd_data),
      .rvalid_q    (rd_valid)
   );

   assign mem_cs1_n = ~sel_q;
   assign mem_cs2   = sel_q;
   assign mem_we_n  = ~wen_q;
   assign mem_oe_n  = ~oen_q;
   assign mem_dq_oe = drv_q;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk
   import asram_ctl_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int DATA_W  = 8,
   parameter int CLK_NS  = 10,
   parameter int T_WP_NS = 40,
   parameter int T_HZ_NS = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs1_n,
   input logic              mem_cs2,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   localparam int WP_MIN = ns2cyc(T_WP_NS, CLK_NS);
   localparam int HZ_CYC = ns2cyc(T_HZ_NS, CLK_NS);

   logic [7:0] we_low_cnt;
   logic [7:0] since_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         we_low_cnt <= '0;
      else if (!mem_we_n)
         we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
      else
         we_low_cnt <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_oe <= 8'hFF;
      else if (!mem_oe_n)
         since_oe <= '0;
      else if (since_oe != 8'hFF)
         since_oe <= since_oe + 8'd1;
   end

   assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_we_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));

   assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_window_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

   assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt >= 8'(WP_MIN)));

   assert_hold_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs1_n && mem_cs2 &&
                           $stable(mem_addr) && $stable(mem_dq_out)));

   assert_rvalid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (since_oe >= 8'(HZ_CYC)));

endmodule

bind asram_ctl asram_ctl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .CLK_NS  (CLK_NS),
   .T_WP_NS (T_WP_NS),
   .T_HZ_NS (T_HZ_NS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_addr   (mem_addr),
   .mem_cs1_n  (mem_cs1_n),
   .mem_cs2    (mem_cs2),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctl_tb.sv
module asram_ctl_tb;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int TCLK = 8;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + TCLK - 1) / TCLK;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // expected counts from R10, fast-grade minimums
   localparam int E_AS = 1;
   int e_wp, e_wt, e_rd, e_ta;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;

   always #(TCLK/2) clk = ~clk;

   asram_ctl #(.CLK_NS(TCLK)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .mem_addr   (mem_addr),
      .mem_cs1_n  (mem_cs1_n),
      .mem_cs2    (mem_cs2),
      .mem_we_n   (mem_we_n),
      .mem_oe_n   (mem_oe_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_in  (mem_dq_in),
      .mem_dq_oe  (mem_dq_oe)
   );

   int vectors = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   // ---------------- behavioural memory model ----------------
   logic [DW-1:0] mem [int];
   logic [DW-1:0] shadow [int];

   function automatic logic [DW-1:0] mrd(input int a);
      return mem.exists(a) ? mem[a] : '0;
   endfunction
   function automatic logic [DW-1:0] srd(input int a);
      return shadow.exists(a) ? shadow[a] : '0;
   endfunction

   wire          m_sel   = !mem_cs1_n && mem_cs2;
   wire          m_drive = m_sel && !mem_oe_n && mem_we_n;
   int           lag = 0;
   logic [DW-1:0] lag_val = '0;
   logic [DW-1:0] mdata;
   always_comb mdata = mrd(int'(mem_addr));
   assign mem_dq_in = m_drive ? mdata : ((lag > 0) ? lag_val : '0);

   bit            win_prev = 1'b0;
   int            win_len = 0;
   logic [DW-1:0] win_d = '0;
   logic [AW-1:0] win_a = '0;

   // ---------------- reference model (phase counter) ----------------
   int            kind = 0;   // 0 idle, 1 write, 2 read
   int            ph = 0;
   logic [AW-1:0] e_addr = '0;
   logic [DW-1:0] e_wd = '0;
   logic [DW-1:0] e_rd_val = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         kind = 0;
         ph = 0;
      end else if (kind == 0) begin
         if (req_valid) begin
            kind = req_write ? 1 : 2;
            ph = 1;
            e_addr = req_addr;
            if (req_write) begin
               e_wd = req_wdata;
               shadow[int'(req_addr)] = req_wdata;
            end else begin
               e_rd_val = srd(int'(req_addr));
            end
         end
      end else begin
         ph++;
         if (kind == 1 && ph > E_AS + e_wp + e_wt) kind = 0;
         if (kind == 2 && ph > e_rd + e_ta) kind = 0;
      end
   end

   // ---------------- per-cycle comparison and memory checks ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         bit x_sel, x_we, x_oe, x_drv, x_rv;
         // memory-side window tracking (R4, R5)
         if (m_sel && !mem_we_n) begin
            if (!win_prev) begin
               win_len = 0;
               win_d = mem_dq_out;
               win_a = mem_addr;
            end
            win_len++;
            chk(mem_dq_out == win_d, "R4 data stable in window", mem_dq_out, win_d);
            chk(mem_addr == win_a, "R4 address stable in window", mem_addr, win_a);
            win_prev = 1'b1;
         end else if (win_prev) begin
            win_prev = 1'b0;
            chk(win_len >= cyc(40), "R4 write pulse width", win_len, cyc(40));
            chk(mem_dq_oe && mem_dq_out == win_d, "R5 data held past window", mem_dq_out, win_d);
            mem[int'(win_a)] = mem_dq_out;
         end
         // bus contention, including memory release lag (R8)
         chk(!(mem_dq_oe && (m_drive || lag > 0)), "R8 bus contention", mem_dq_oe, 0);
         if (m_drive) begin
            lag = cyc(20);
            lag_val = mdata;
         end else if (lag > 0) begin
            lag--;
         end

         // reference comparison
         x_sel = (kind == 1) || (kind == 2 && ph <= e_rd);
         x_we  = (kind == 1) && ph > E_AS && ph <= E_AS + e_wp;
         x_oe  = (kind == 2) && ph <= e_rd;
         x_drv = (kind == 1);
         x_rv  = (kind == 2) && ph == e_rd + 1;
         chk(req_ready == (kind == 0), "R2 ready only when idle", req_ready, kind == 0);
         chk(mem_cs1_n == !x_sel && mem_cs2 == x_sel, "R1/R3/R6 selects",
             {mem_cs1_n, mem_cs2}, {!x_sel, x_sel});
         chk(mem_we_n == !x_we, "R4 write enable timing", mem_we_n, !x_we);
         chk(mem_oe_n == !x_oe, "R6 output enable timing", mem_oe_n, !x_oe);
         chk(mem_dq_oe == x_drv, "R3/R5/R9 driver enable", mem_dq_oe, x_drv);
         chk(rd_valid == x_rv, "R7 read strobe timing", rd_valid, x_rv);
         if (x_sel) chk(mem_addr == e_addr, "R3/R6 address", mem_addr, e_addr);
         if (x_drv) chk(mem_dq_out == e_wd, "R3 write data", mem_dq_out, e_wd);
         if (x_rv)  chk(rd_data == e_rd_val, "R7 read data", rd_data, e_rd_val);
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit w, input int a, input int d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = AW'(a);
      req_wdata = DW'(d);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      e_wp = mx(mx(cyc(40), cyc(25)), mx(cyc(45) - E_AS, cyc(45) - E_AS));
      e_wt = mx(cyc(0), cyc(55) - E_AS - e_wp);
      e_rd = mx(cyc(55), mx(cyc(55), cyc(25)));
      e_ta = cyc(20);
      // R10: counts with an 8 ns clock
      chk(e_wp == 5 && e_wt == 1 && e_rd == 7 && e_ta == 3, "R10 cycle counts",
          e_wp * 1000 + e_wt * 100 + e_rd * 10 + e_ta, 5173);

      settle(3);
      // R1: reset state
      chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid,
          "R1 reset state",
          {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rd_valid}, 7'b1011010);
      rst_n = 1'b1;
      settle(2);

      // write then read at address extremes
      issue(1, 0, 8'hA5);
      issue(0, 0, 0);
      issue(1, 17'h1FFFF, 8'h3C);
      issue(0, 17'h1FFFF, 0);
      issue(0, 0, 0);
      issue(0, 17'h00123, 0);           // never written: reads zero (R7)

      // R8: write queued directly behind a read (turnaround vs. driver)
      issue(0, 17'h1FFFF, 0);
      issue(1, 17'h00077, 8'h5A);
      issue(0, 17'h00077, 0);

      // R2: request inputs toggled while busy are ignored
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_wdata = 8'h11;
      @(negedge clk);
      req_addr = 17'h00155; req_wdata = 8'hFF;
      settle(3);
      req_valid = 1'b0;
      settle(12);
      issue(0, 17'h00155, 0);
      issue(0, 17'h00042, 0);

      // mixed pattern
      for (int i = 0; i < 24; i++) begin
         int a;
         a = (i * 7919) & 17'h1FFFF;
         if (i % 3 != 2) issue(1, a, (i * 37 + 1) & 8'hFF);
         issue(0, a, 0);
      end
      settle(16);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule